// File: doc/BRIEF.md
# Byte ALU with carry flags

This unit is the 8-bit execute stage of a small accumulator-style processor. Each cycle it is handed the working register value, a file-register operand, an 8-bit literal, a 4-bit operation code and a destination bit. When the commit strobe is high, it registers a result byte, a flag saying whether that byte belongs in the working register or back in the file register, a five-bit status set (negative, overflow, carry, digit carry, zero) and a 16-bit product pair.

The carry that feeds rotates and subtract-with-borrow is the unit's own stored carry flag. Every operation updates only its own subset of flags, and the rest keep their values. Multiplies touch only the product pair. Register-file storage, instruction fetch and bank addressing are handled elsewhere.

Top module: `byte_alu`

## Requirements
- R1: After reset, every output is zero: result, destination, result-valid, all five flags and the product.
- R2: Opcode 0 (rotate left through carry) yields {f[6:0], C} and sets C to old f[7]. Opcode 1 (rotate right through carry) yields {C, f[7:1]} and sets C to old f[0]. OV and DC hold.
- R3: Opcode 2 (rotate left, no carry) yields {f[6:0], f[7]}. Opcode 3 (rotate right, no carry) yields {f[0], f[7:1]}. C, OV and DC hold.
- R4: Opcode 5 (subtract with borrow) yields W - f - (1 - C) modulo 256. C becomes 1 when no borrow occurs, DC becomes 1 when the low nibble needs no borrow, and OV becomes 1 when the signed difference leaves -128..127.
- R5: Opcode 4 (negate) yields 0 - f modulo 256. C is 1 only for f = 0x00, DC is 1 only when f[3:0] = 0, and OV is 1 only for f = 0x80.
- R6: For opcodes 0 to 5, N equals bit 7 of the new result and Z is 1 exactly when the new result is 0x00.
- R7: Opcode 6 (set all ones) yields 0xFF with destination f (1), and all flags hold.
- R8: Opcode 7 (literal load) yields k with destination W (0), and all flags hold.
- R9: Opcode 8 multiplies W by k and opcode 9 multiplies W by f, both unsigned. The product output takes the 16-bit result with the high byte in bits 15:8. Flags, result byte and destination hold, and result-valid stays low.
- R10: For opcodes 0 to 5, the destination output copies the d input (0 = W, 1 = f).
- R11: With the strobe low, or with opcodes 10 to 15, no output changes except that result-valid is 0.
- R12: All outputs change only on the clock edge that samples the strobe. Result-valid is 1 for exactly the one cycle after a strobe carrying opcodes 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit | input | 1 | Write-enable strobe for all results and flags |
| opc | input | 4 | Operation code |
| to_file | input | 1 | Destination bit d (0 = W, 1 = f) |
| w_val | input | 8 | Working register value |
| f_val | input | 8 | File register operand |
| lit | input | 8 | Literal operand |
| result | output | 8 | Registered result byte |
| result_to_file | output | 1 | Destination of result (0 = W, 1 = f) |
| result_vld | output | 1 | Result byte written this cycle |
| flag_n | output | 1 | Negative flag |
| flag_ov | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_dc | output | 1 | Digit carry / no-borrow out of bit 3 |
| flag_z | output | 1 | Zero flag |
| product | output | 16 | Product pair, high byte in bits 15:8 |

## Verification
Every result, flag and product value is due one cycle after the strobe: it is set up on the same edge that samples the operands. The bench applies a new operation at each falling edge. At the next falling edge, one full cycle later and after the single register stage has loaded, it compares the complete output set against its reference model. Idle cycles and unused opcodes are compared in the same way, so any flag that should hold is checked one cycle after the stimulus that could have changed it.

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int DW = 8,
  parameter int OPW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [OPW-1:0]  opc,
  input  logic            to_file,
  input  logic [DW-1:0]   w_val,
  input  logic [DW-1:0]   f_val,
  input  logic [DW-1:0]   lit,
  output logic [DW-1:0]   result,
  output logic            result_to_file,
  output logic            result_vld,
  output logic            flag_n,
  output logic            flag_ov,
  output logic            flag_c,
  output logic            flag_dc,
  output logic            flag_z,
  output logic [2*DW-1:0] product
);
  localparam int HB = DW / 2;

  logic          is_neg;
  logic [DW-1:0] a_op;
  logic          cin;
  logic [DW:0]   diff;
  logic [HB:0]   ndiff;
  logic          ovf;

  assign is_neg = (opc == OPW'(4));
  assign a_op   = is_neg ? '0 : w_val;
  assign cin    = is_neg ? 1'b1 : flag_c;
  assign diff   = {1'b0, a_op} + {1'b0, ~f_val} + (DW+1)'(cin);
  assign ndiff  = {1'b0, a_op[HB-1:0]} + {1'b0, ~f_val[HB-1:0]} + (HB+1)'(cin);
  assign ovf    = (a_op[DW-1] != f_val[DW-1]) && (diff[DW-1] != a_op[DW-1]);

  logic [DW-1:0] r;
  logic          wr_res, dst, up_nz, up_c, up_arith, c_new, up_prod;
  logic [DW-1:0] m_op;

  always_comb begin
    r        = result;
    wr_res   = 1'b1;
    dst      = to_file;
    up_nz    = 1'b1;
    up_c     = 1'b0;
    up_arith = 1'b0;
    c_new    = flag_c;
    up_prod  = 1'b0;
    m_op     = lit;
    case (opc)
      OPW'(0): begin r = {f_val[DW-2:0], flag_c}; up_c = 1'b1; c_new = f_val[DW-1]; end
      OPW'(1): begin r = {flag_c, f_val[DW-1:1]}; up_c = 1'b1; c_new = f_val[0]; end
      OPW'(2): r = {f_val[DW-2:0], f_val[DW-1]};
      OPW'(3): r = {f_val[0], f_val[DW-1:1]};
      OPW'(4), OPW'(5): begin
        r = diff[DW-1:0]; up_c = 1'b1; up_arith = 1'b1; c_new = diff[DW];
      end
      OPW'(6): begin r = '1; dst = 1'b1; up_nz = 1'b0; end
      OPW'(7): begin r = lit; dst = 1'b0; up_nz = 1'b0; end
      OPW'(8), OPW'(9): begin
        wr_res = 1'b0; up_nz = 1'b0; up_prod = 1'b1;
        m_op = (opc == OPW'(9)) ? f_val : lit;
      end
      default: begin wr_res = 1'b0; up_nz = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result         <= '0;
      result_to_file <= 1'b0;
      result_vld     <= 1'b0;
      flag_n         <= 1'b0;
      flag_ov        <= 1'b0;
      flag_c         <= 1'b0;
      flag_dc        <= 1'b0;
      flag_z         <= 1'b0;
      product        <= '0;
    end else begin
      result_vld <= commit && wr_res;
      if (commit) begin
        if (wr_res) begin
          result         <= r;
          result_to_file <= dst;
        end
        if (up_nz) begin
          flag_n <= r[DW-1];
          flag_z <= (r == '0);
        end
        if (up_c) flag_c <= c_new;
        if (up_arith) begin
          flag_ov <= ovf;
          flag_dc <= ndiff[HB];
        end
        if (up_prod) product <= w_val * m_op;
      end
    end
  end
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
  parameter int DW = 8,
  parameter int OPW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            commit,
  input logic [OPW-1:0]  opc,
  input logic [DW-1:0]   lit,
  input logic [DW-1:0]   result,
  input logic            result_to_file,
  input logic            result_vld,
  input logic            flag_n,
  input logic            flag_ov,
  input logic            flag_c,
  input logic            flag_dc,
  input logic            flag_z,
  input logic [2*DW-1:0] product
);
  logic [4:0] flags;
  assign flags = {flag_n, flag_ov, flag_c, flag_dc, flag_z};

  AST_NOCARRY_ROT_HOLDS_C: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (opc == OPW'(2) || opc == OPW'(3)) |=> $stable(flag_c) && $stable(flag_ov) && $stable(flag_dc)); // R3
  AST_NZ_TRACK_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    commit && opc <= OPW'(5) |=> (flag_n == result[DW-1]) && (flag_z == (result == '0))); // R6
  AST_SETALL_TO_FILE: assert property (@(posedge clk) disable iff (!rst_n)
    commit && opc == OPW'(6) |=> result == '1 && result_to_file && $stable(flags)); // R7
  AST_LIT_TO_W: assert property (@(posedge clk) disable iff (!rst_n)
    commit && opc == OPW'(7) |=> result == $past(lit) && !result_to_file && $stable(flags)); // R8
  AST_MUL_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (opc == OPW'(8) || opc == OPW'(9)) |=> $stable(flags) && $stable(result) && !result_vld); // R9
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(flags) && $stable(result) && $stable(product) && !result_vld); // R11
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit && opc <= OPW'(7) |=> result_vld); // R12
endmodule

bind byte_alu byte_alu_chk #(.DW(DW), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .opc(opc), .lit(lit),
  .result(result), .result_to_file(result_to_file), .result_vld(result_vld),
  .flag_n(flag_n), .flag_ov(flag_ov), .flag_c(flag_c), .flag_dc(flag_dc),
  .flag_z(flag_z), .product(product)
);

// File: tb/sim_byte_alu.sv
module sim_byte_alu;
  logic clk = 0, rst_n = 0;
  logic commit = 0, to_file = 0;
  logic [3:0] opc = 0;
  logic [7:0] w_val = 0, f_val = 0, lit = 0;
  logic [7:0] result;
  logic result_to_file, result_vld, flag_n, flag_ov, flag_c, flag_dc, flag_z;
  logic [15:0] product;

  always #4 clk = ~clk;

  byte_alu u0 (.clk(clk), .rst_n(rst_n), .commit(commit), .opc(opc), .to_file(to_file),
    .w_val(w_val), .f_val(f_val), .lit(lit), .result(result), .result_to_file(result_to_file),
    .result_vld(result_vld), .flag_n(flag_n), .flag_ov(flag_ov), .flag_c(flag_c),
    .flag_dc(flag_dc), .flag_z(flag_z), .product(product));

  int checks = 0, fails = 0;
  bit done = 0;
  int m_res = 0, m_dst = 0, m_vld = 0, m_n = 0, m_ov = 0, m_c = 0, m_dc = 0, m_z = 0, m_prod = 0;
  string pend = "R1";

  function automatic logic [31:0] act_vec();
    return {result_vld, result_to_file, result, flag_n, flag_ov, flag_c, flag_dc, flag_z, product[12:0]};
  endfunction
  function automatic logic [31:0] exp_vec();
    logic [15:0] p = m_prod[15:0];
    return {m_vld[0], m_dst[0], m_res[7:0], m_n[0], m_ov[0], m_c[0], m_dc[0], m_z[0], p[12:0]};
  endfunction

  task automatic compare();
    checks++;
    if (act_vec() !== exp_vec() || product !== m_prod[15:0]) begin
      fails++;
      $display("FAIL %s: actual vld/dst/res/nvcdz=%b/%b/%h/%b%b%b%b%b prod=%h expected %0d/%0d/%h/%0d%0d%0d%0d%0d prod=%h",
        pend, result_vld, result_to_file, result, flag_n, flag_ov, flag_c, flag_dc, flag_z, product,
        m_vld, m_dst, m_res, m_n, m_ov, m_c, m_dc, m_z, m_prod);
    end
  endtask

  task automatic step(string tag, bit s, int op, bit d, int w, int f, int k);
    int r, ws, fs, sd;
    @(negedge clk);
    compare();
    commit = s; opc = op[3:0]; to_file = d; w_val = w[7:0]; f_val = f[7:0]; lit = k[7:0];
    pend = tag;
    m_vld = 0;
    if (!s || op > 9) return;
    r = -1;
    case (op)
      0: begin r = ((f * 2) % 256) + m_c; m_c = f / 128; end
      1: begin r = m_c * 128 + f / 2; m_c = f % 2; end
      2: r = ((f * 2) % 256) + f / 128;
      3: r = (f % 2) * 128 + f / 2;
      4: begin
        r = (256 - f) % 256; m_c = (f == 0); m_dc = (f % 16 == 0); m_ov = (f == 128);
      end
      5: begin
        ws = (w > 127) ? w - 256 : w; fs = (f > 127) ? f - 256 : f;
        sd = ws - fs - (1 - m_c);
        m_dc = ((w % 16) - (f % 16) - (1 - m_c)) >= 0;
        m_c = (w - f - (1 - m_c)) >= 0;
        m_ov = (sd < -128) || (sd > 127);
        r = (w - f - (m_c == m_c ? 0 : 0));
        r = ((sd % 256) + 256) % 256;
      end
      6: begin m_res = 255; m_dst = 1; m_vld = 1; end
      7: begin m_res = k; m_dst = 0; m_vld = 1; end
      8: m_prod = w * k;
      9: m_prod = w * f;
      default: ;
    endcase
    if (op <= 5) begin
      m_res = r; m_dst = d; m_vld = 1; m_n = (r >= 128); m_z = (r == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (act_vec() !== 32'd0 || product !== 16'd0) begin
      fails++; $display("FAIL R1: actual %h expected 0", act_vec());
    end
    rst_n = 1;
    step("R2 rlc", 1, 0, 0, 0, 8'hE6, 0);       // 0xCC, C=1
    step("R2 rrc", 1, 1, 1, 0, 8'hE6, 0);       // C in=1 -> 0xF3, C=0
    step("R12 idle", 0, 0, 0, 0, 8'hFF, 0);
    step("R3 rlnc", 1, 2, 1, 0, 8'hAB, 0);      // 0x57
    step("R3 rrnc", 1, 3, 0, 0, 8'hD7, 0);      // 0xEB
    step("R6 rlnc zero", 1, 2, 0, 0, 8'h00, 0);
    step("R2 rlc set C", 1, 0, 1, 0, 8'h80, 0); // zero result, C=1
    step("R3 rrnc keep C", 1, 3, 0, 0, 8'h01, 0);
    step("R4 subb 2-3", 1, 5, 1, 2, 3, 0);      // 0xFF C=0 N=1
    step("R4 subb 5-2 borrow", 1, 5, 0, 5, 2, 0); // C=0 -> 2
    step("R4 subb 2-1 z", 1, 5, 1, 2, 1, 0);    // C=1? depends on model
    step("R4 subb ovf", 1, 5, 0, 8'h80, 8'h01, 0);
    step("R4 subb nibble", 1, 5, 1, 8'h10, 8'h01, 0);
    step("R5 neg 3A", 1, 4, 1, 0, 8'h3A, 0);    // 0xC6
    step("R5 neg 00", 1, 4, 1, 0, 8'h00, 0);
    step("R5 neg 80", 1, 4, 0, 0, 8'h80, 0);
    step("R5 neg 10", 1, 4, 1, 0, 8'h10, 0);
    step("R7 setall", 1, 6, 0, 0, 8'h5A, 0);
    step("R8 literal", 1, 7, 1, 0, 0, 8'h5A);
    step("R9 mul k", 1, 8, 1, 8'hE2, 0, 8'hC4); // 0xAD08
    step("R9 mul f", 1, 9, 0, 8'hC4, 8'hB5, 0); // 0x8A94
    step("R9 mul zero", 1, 8, 0, 8'h00, 0, 8'hFF);
    step("R11 unused op", 1, 12, 1, 8'h11, 8'h22, 8'h33);
    step("R11 no strobe", 0, 5, 1, 8'h99, 8'h01, 0);
    step("R10 dest W", 1, 1, 0, 0, 8'h0F, 0);
    step("R10 dest f", 1, 0, 1, 0, 8'hF0, 0);
    step("R11 no strobe mul", 0, 9, 0, 8'hFF, 8'hFF, 0);
    for (int i = 0; i < 40; i++)
      step("R4 sweep", 1, (i % 3 == 0) ? 4 : 5, i[0], (i * 37) % 256, (i * 91 + 5) % 256, 0);
    step("R12 final idle", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL R12: watchdog expired, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule